// File: doc/BRIEF.md
# Dual-Slope Complementary PWM Generator

This block produces a pair of complementary pulse-width-modulated waveforms from one up/down counter. The counter climbs from zero to a programmable ceiling, then descends back to zero, and repeats. Each output is driven by a compare threshold of its own. Whether a match sets or clears the output depends on which way the counter is moving. When the two thresholds sit a few counts either side of mid-range, the outputs carry equal duty cycle and are separated by a guard interval of non-overlap. This makes them suitable for driving the high-side and low-side switches of a half bridge.

A host programs the block through a small write-only register port. The port holds a control word with a run bit and a prescaler select, the counter ceiling, the two thresholds and two channel-enable bits. The prescaler select can only change while the timer is stopped. A ready flag tells the host when a start request will be honoured. Ceiling and threshold writes go to shadow copies. The counter adopts these copies at the end of a cycle, or at once while the timer is stopped.

Top module: `dspwm_top`

## Requirements
- R1: While running, the counter visits 0,1,...,TOP,TOP,...,1,0 and then repeats. One output cycle therefore lasts 2*(TOP+1) prescaler ticks. TOP is written at address 1.
- R2: Output A is set when the counter equals threshold A while descending, and cleared when it equals threshold A while ascending. Its high time is 2*A+1 ticks. Threshold A is written at address 2.
- R3: Output B is set when the counter equals threshold B while ascending, and cleared when it equals threshold B while descending. Its high time is 2*(TOP-B)+1 ticks. Threshold B is written at address 3.
- R4: With A < B, output B rises B-A ticks after output A falls, and the pins are never high together.
- R5: Control register (address 0): bit 0 is the run bit, bits 2:1 select the prescaler. Code 0 divides by 1, code 1 by 4, and codes 2 and 3 by 32. One counter step takes one prescaler tick.
- R6: A control write while running leaves the prescaler select unchanged; only the run bit is taken.
- R7: The ready output is high only while the timer is stopped and at least SYNC_CYCLES clocks have passed since reset or since the last stop. A request to set the run bit while ready is low is ignored.
- R8: Address 4 holds the channel enables: bit 0 for A, bit 1 for B. A pin whose enable is 0 stays low.
- R9: Clearing the run bit returns the counter to 0 counting up, and drives both pins low within two clocks. After a restart at divide-by-1, pin B first goes high B+2 clocks after the edge that sets the run bit.
- R10: Ceiling and threshold writes made while running take effect only once the counter has finished descending to zero.
- R11: After reset both pins are low and ready is low; ready rises at the SYNC_CYCLES-th clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 ceiling, 2 threshold A, 3 threshold B, 4 channel enables) |
| wr_data | input | CNT_W | Write data |
| en_ready | output | 1 | High when a start request will be honoured |
| pin_a | output | 1 | Gated output A |
| pin_b | output | 1 | Gated output B |

## Verification
A compare match changes a waveform register at the clock edge that processes that counter state. The pin register follows one clock later, so every pin edge trails its match by one clock. The bench therefore measures durations as differences between pin edges sampled on falling clock edges, where this fixed latency cancels. The restart test counts clocks from the edge that sets the run bit, so the expected value there adds the two register stages to B. Ready is sampled at exact clock counts after reset release, and pins are sampled three clocks after a stop, past the two-register path that clears them.

// File: rtl/dspwm_pkg.sv
`timescale 1ns/1ps
package dspwm_pkg;
  typedef enum logic [1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV4   = 2'd1,
    PRE_DIV32  = 2'd2,
    PRE_DIV32B = 2'd3
  } presc_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_TOP  = 3'd1;
  localparam logic [2:0] ADDR_CMPA = 3'd2;
  localparam logic [2:0] ADDR_CMPB = 3'd3;
  localparam logic [2:0] ADDR_CHEN = 3'd4;
endpackage

// File: rtl/dspwm_regs.sv
`timescale 1ns/1ps
module dspwm_regs
  import dspwm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             run,
  output presc_e           presc_sel,
  output logic [CNT_W-1:0] shd_top,
  output logic [CNT_W-1:0] shd_cmpa,
  output logic [CNT_W-1:0] shd_cmpb,
  output logic [1:0]       chan_en,
  output logic             ready
);
  localparam int SW = $clog2(SYNC_CYCLES + 1);
  localparam logic [SW-1:0] SYNC_LIM = SW'(SYNC_CYCLES);

  logic [SW-1:0] sync_cnt;
  logic          ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign ready   = !run && (sync_cnt == SYNC_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      presc_sel <= PRE_DIV1;
      shd_top   <= '1;
      shd_cmpa  <= '0;
      shd_cmpb  <= '0;
      chan_en   <= 2'b00;
      sync_cnt  <= '0;
    end else begin
      if (ctrl_wr) begin
        // protected field: only while stopped
        if (!run) presc_sel <= presc_e'(wr_data[2:1]);
        if (!wr_data[0])  run <= 1'b0;
        else if (ready)   run <= 1'b1;
      end
      if (wr_en && wr_addr == ADDR_TOP)  shd_top  <= wr_data;
      if (wr_en && wr_addr == ADDR_CMPA) shd_cmpa <= wr_data;
      if (wr_en && wr_addr == ADDR_CMPB) shd_cmpb <= wr_data;
      if (wr_en && wr_addr == ADDR_CHEN) chan_en  <= wr_data[1:0];
      if (run)                      sync_cnt <= '0;
      else if (sync_cnt != SYNC_LIM) sync_cnt <= sync_cnt + SW'(1);
    end
  end
endmodule

// File: rtl/dspwm_prescaler.sv
`timescale 1ns/1ps
module dspwm_prescaler
  import dspwm_pkg::*;
#(
  parameter int DIV_MID = 4,
  parameter int DIV_HI  = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  presc_e sel,
  output logic   tick
);
  localparam int PW = $clog2(DIV_HI);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_comb begin
    case (sel)
      PRE_DIV1: lim = '0;
      PRE_DIV4: lim = PW'(DIV_MID - 1);
      default:  lim = PW'(DIV_HI - 1);
    endcase
  end

  assign tick = run && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)  pcnt <= '0;
    else if (tick)    pcnt <= '0;
    else              pcnt <= pcnt + PW'(1);
  end
endmodule

// File: rtl/dspwm_core.sv
`timescale 1ns/1ps
module dspwm_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] shd_top,
  input  logic [CNT_W-1:0] shd_cmpa,
  input  logic [CNT_W-1:0] shd_cmpb,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_top,
  output logic [1:0]       wave
);
  logic             cnt_down;
  logic [CNT_W-1:0] act_cmpa;
  logic [CNT_W-1:0] act_cmpb;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cnt_down <= 1'b0;
      wave     <= 2'b00;
      act_top  <= '0;
      act_cmpa <= '0;
      act_cmpb <= '0;
    end else if (!run) begin
      cnt      <= '0;
      cnt_down <= 1'b0;
      wave     <= 2'b00;
      act_top  <= shd_top;
      act_cmpa <= shd_cmpa;
      act_cmpb <= shd_cmpb;
    end else if (tick) begin
      // A: set descending, clear ascending. B: the reverse.
      if (cnt == act_cmpa) wave[0] <= cnt_down;
      if (cnt == act_cmpb) wave[1] <= !cnt_down;
      if (!cnt_down) begin
        if (cnt == act_top) cnt_down <= 1'b1;
        else                cnt      <= cnt + CNT_W'(1);
      end else begin
        if (cnt == '0) begin
          cnt_down <= 1'b0;
          act_top  <= shd_top;
          act_cmpa <= shd_cmpa;
          act_cmpb <= shd_cmpb;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dspwm_top.sv
`timescale 1ns/1ps
module dspwm_top
  import dspwm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_MID     = 4,
  parameter int DIV_HI      = 32,
  parameter int SYNC_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             en_ready,
  output logic             pin_a,
  output logic             pin_b
);
  localparam int NCH = 2;

  logic             run;
  presc_e           presc_sel;
  logic [CNT_W-1:0] shd_top, shd_cmpa, shd_cmpb;
  logic [NCH-1:0]   chan_en;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_top;
  logic [NCH-1:0]   wave;
  logic [NCH-1:0]   pin_q;

  dspwm_regs #(.CNT_W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .presc_sel(presc_sel), .shd_top(shd_top), .shd_cmpa(shd_cmpa),
    .shd_cmpb(shd_cmpb), .chan_en(chan_en), .ready(en_ready)
  );

  dspwm_prescaler #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_pre (
    .clk(clk), .rst(rst), .run(run), .sel(presc_sel), .tick(tick)
  );

  dspwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .shd_top(shd_top),
    .shd_cmpa(shd_cmpa), .shd_cmpb(shd_cmpb), .cnt(cnt), .act_top(act_top),
    .wave(wave)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) pin_q[ch] <= 1'b0;
      else     pin_q[ch] <= wave[ch] & chan_en[ch];
    end
  end

  assign pin_a = pin_q[0];
  assign pin_b = pin_q[1];
endmodule

// File: rtl/dspwm_chk.sv
`timescale 1ns/1ps
module dspwm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             ready,
  input logic [1:0]       presc_sel,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_top,
  input logic             pin_a,
  input logic             pin_b
);
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(pin_a && pin_b));

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> ##2 (!pin_a && !pin_b));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= act_top));

  // R6
  presc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(presc_sel));

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> !ready);

  // R7
  start_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(ready));
endmodule

bind dspwm_top dspwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ready(en_ready), .presc_sel(presc_sel),
  .cnt(cnt), .act_top(act_top), .pin_a(pin_a), .pin_b(pin_b)
);

// File: tb/tb_dspwm_top.sv
`timescale 1ns/1ps
module tb_dspwm_top;
  localparam int CNT_W = 8;
  localparam int NV    = 5;
  // top, cmpA, cmpB, presc code | period, highA, highB, gap (clocks)
  localparam int VEC [0:NV-1][0:7] = '{
    '{200, 99, 101, 0,  402, 199, 199,  2},
    '{ 20,  8,  12, 0,   42,  17,  17,  4},
    '{ 10,  3,   6, 1,   88,  28,  36, 12},
    '{  5,  1,   3, 2,  384,  96, 160, 64},
    '{  3,  1,   2, 3,  256,  96,  96, 32}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             en_ready, pin_a, pin_b;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int both_hi = 0;

  dspwm_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_ready(en_ready), .pin_a(pin_a), .pin_b(pin_b)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (pin_a && pin_b) both_hi++;

  always @(posedge clk) begin
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pin(input int ch, input logic lvl, output int t);
    int guard = 0;
    while (((ch == 0) ? pin_a : pin_b) !== lvl && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    t = cyc;
  endtask

  task automatic start(input int top, input int a, input int b, input int sel);
    int guard = 0;
    wr(3'd0, 0);
    wr(3'd1, top); wr(3'd2, a); wr(3'd3, b); wr(3'd4, 3);
    while (!en_ready && guard < 50) begin @(negedge clk); guard++; end
    wr(3'd0, (sel << 1) | 1);
  endtask

  task automatic measure(output int per, output int ha, output int hb, output int gap);
    int t0, t1, t2, t3, t4, t5;
    wait_pin(0, 1'b0, t0);
    wait_pin(0, 1'b1, t1);
    wait_pin(0, 1'b0, t2);
    wait_pin(1, 1'b1, t3);
    wait_pin(1, 1'b0, t4);
    wait_pin(0, 1'b1, t5);
    per = t5 - t1; ha = t2 - t1; hb = t4 - t3; gap = t3 - t2;
  endtask

  initial begin
    int per, ha, hb, gap, t0, t1, hits_a, hits_b;
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 pin_a in reset", int'(pin_a), 0);
    check("R11 pin_b in reset", int'(pin_b), 0);
    rst = 1'b0;
    check("R11 ready at release", int'(en_ready), 0);
    repeat (3) @(negedge clk);
    check("R7 ready before sync", int'(en_ready), 0);
    @(negedge clk);
    check("R11 ready after sync", int'(en_ready), 1);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      start(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      check("R7 ready low while running", int'(en_ready), 0);
      both_hi = 0;
      measure(per, ha, hb, gap);
      check("R1 R5 period", per, VEC[i][4]);
      check("R2 high A", ha, VEC[i][5]);
      check("R3 high B", hb, VEC[i][6]);
      check("R4 dead gap", gap, VEC[i][7]);
      check("R4 both high count", both_hi, 0);
    end

    // R6: prescaler write while running ignored
    start(20, 8, 12, 0);
    wr(3'd0, (2 << 1) | 1);
    measure(per, ha, hb, gap);
    check("R6 period after protected write", per, 42);

    // R10: shadow values adopted at cycle end
    wait_pin(0, 1'b0, t0);
    wait_pin(0, 1'b1, t0);
    wr(3'd1, 40); wr(3'd2, 18); wr(3'd3, 22);
    wait_pin(0, 1'b0, t1);
    check("R10 high A across boundary", t1 - t0, 27);
    wait_pin(1, 1'b1, t0);
    check("R10 gap with new thresholds", t0 - t1, 4);

    // R8: channel gating
    wr(3'd4, 2);
    repeat (3) @(negedge clk);
    hits_a = 0; hits_b = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (pin_a) hits_a++;
      if (pin_b) hits_b++;
    end
    check("R8 gated A stays low", hits_a, 0);
    check("R8 B still toggles", int'(hits_b > 0), 1);
    wr(3'd4, 3);

    // R9: stop forces low; R7 start while not ready ignored
    wr(3'd0, 0);
    wr(3'd0, 1);
    @(negedge clk);
    check("R9 pin_a low after stop", int'(pin_a), 0);
    check("R9 pin_b low after stop", int'(pin_b), 0);
    hits_a = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pin_a || pin_b) hits_a++;
    end
    check("R7 early start ignored, pins idle", hits_a, 0);
    check("R7 still stopped so ready high", int'(en_ready), 1);

    // R9: restart from zero counting up (thresholds 18/22, top 40)
    wr(3'd0, 1);
    t0 = cyc;
    wait_pin(1, 1'b1, t1);
    check("R9 first B rise after restart", t1 - t0, 22 + 2);

    wr(3'd0, 0);
    repeat (3) @(negedge clk);
    check("R9 final stop pins", int'(pin_a | pin_b), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule